// File: doc/BRIEF.md
# Block-Compressed Global History Register

This block keeps a global branch history that grows by at most one bit per fetch block instead of one bit per branch. Each cycle up to two fetch blocks arrive, in program order, on two lanes. For every block the front end reports four things:

- whether the lane holds a block;
- whether that block contains a conditional branch;
- the direction of the last conditional branch in it;
- which half of the 8-instruction block that branch sits in.

A block that ends on a conditional branch contributes the branch direction XOR its half flag. This means the branch position is encoded in the bit, and earlier branches in the block are taken as not taken. So the history shifts by 0, 1 or 2 bits per cycle.

Outcomes of the three most recent blocks are not yet resolved when the predictor is indexed. The block therefore also produces an index vector built from three parts:

- the address being predicted;
- the history as it stood three blocks earlier;
- a short path signature folded from the addresses of the three most recent blocks.

A restore port reloads the history after a redirect.

Top module: `blkhist_top`

## Requirements
- R1: While `rst` is high at a clock edge, `hist_o` and `info_o` become all zero on that edge.
- R2: A lane whose block is valid (`blk_vld`=1) and has a conditional branch (`blk_br`=1) shifts `hist_o` left by one. The new LSB is `blk_dir` XOR `blk_half`, where `blk_dir` 1 means taken and `blk_half` 1 means second half.
- R3: A lane that is invalid, or valid with `blk_br`=0, inserts no bit, so `hist_o` is unchanged when no lane inserts.
- R4: When both lanes insert in one cycle, lane 0's bit is shifted in first: `hist_o` becomes {old[HIST_W-3:0], bit0, bit1}.
- R5: The stale field of `info_o` (bits [HIST_W+3*PATH_W-1 : 3*PATH_W]) equals the value `hist_o` held right after the block three valid blocks before the newest one. Every valid block counts, with or without a branch, and blocks are ordered lane 0 before lane 1.
- R6: The path field (`info_o` bits [3*PATH_W-1:0]) holds three PATH_W-bit signatures, most recent valid block in the top slot. Each signature is the XOR of address bits j over all j with the same value of j mod PATH_W.
- R7: The top ADDR_W bits of `info_o` equal `pred_addr` from the previous cycle. All `info_o` fields reflect the updates of the cycle before.
- R8: With `restore` high, `hist_o` and every delayed history snapshot load `restore_val`, overriding any shift. The path signatures still advance normally.
- R9: A valid block on lane 1 with lane 0 invalid is handled as a single block, the same as a lone lane 0 block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_vld | input | LANES | Lane holds a fetch block |
| blk_br | input | LANES | Block contains a conditional branch |
| blk_dir | input | LANES | Direction of last conditional branch (1 = taken) |
| blk_half | input | LANES | Half holding that branch (1 = second half) |
| blk_addr | input | LANES*ADDR_W | Block addresses, lane 0 in the low bits |
| pred_addr | input | ADDR_W | Address being predicted |
| restore | input | 1 | Load history from restore_val |
| restore_val | input | HIST_W | History value to restore |
| hist_o | output | HIST_W | Current compressed history |
| info_o | output | ADDR_W+HIST_W+3*PATH_W | Index vector {address, stale history, path} |

## Verification
The bench builds the block with an 8-bit history, 6-bit addresses and 2-bit path signatures. With these sizes, every combination of the four control flags on both lanes (256 cases) can be swept. The sweep covers double inserts, lane 1 alone, and blocks that advance the snapshots without adding a bit. It runs while the folded path bits stay small enough to follow by hand. Restores are mixed into the sweep at a fixed period, so the override against simultaneous shifts and the snapshot reload are both exercised.

// File: rtl/blkhist_pkg.sv
package blkhist_pkg;
  localparam int LANES = 2;
  localparam int LAG   = 3;

  typedef struct packed {
    logic vld;
    logic br;
    logic dir;
    logic half;
  } blk_ctl_t;
endpackage

// File: rtl/blkhist_lane.sv
module blkhist_lane
  import blkhist_pkg::*;
(
  input  blk_ctl_t ctl,
  output logic     adv,
  output logic     ins,
  output logic     hbit
);
  always_comb begin
    adv  = ctl.vld;
    ins  = ctl.vld & ctl.br;
    hbit = ctl.dir ^ ctl.half;
  end
endmodule

// File: rtl/blkhist_snap.sv
module blkhist_snap
  import blkhist_pkg::*;
#(
  parameter int HIST_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  adv,
  input  logic [LANES-1:0]  ins,
  input  logic [LANES-1:0]  hbit,
  input  logic              restore,
  input  logic [HIST_W-1:0] restore_val,
  output logic [HIST_W-1:0] hist_q,
  output logic [HIST_W-1:0] stale_q
);
  logic [HIST_W-1:0] snap_q [LAG];
  logic [HIST_W-1:0] snap_d [LAG];
  logic [HIST_W-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    for (int k = 0; k < LAG; k++) snap_d[k] = snap_q[k];
    for (int i = 0; i < LANES; i++) begin
      if (adv[i]) begin
        for (int k = LAG-1; k > 0; k--) snap_d[k] = snap_d[k-1];
        snap_d[0] = hist_d;
        if (ins[i]) hist_d = {hist_d[HIST_W-2:0], hbit[i]};
      end
    end
    if (restore) begin
      hist_d = restore_val;
      for (int k = 0; k < LAG; k++) snap_d[k] = restore_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      for (int k = 0; k < LAG; k++) snap_q[k] <= '0;
    end else begin
      hist_q <= hist_d;
      for (int k = 0; k < LAG; k++) snap_q[k] <= snap_d[k];
    end
  end

  assign stale_q = snap_q[LAG-1];
endmodule

// File: rtl/blkhist_path.sv
module blkhist_path
  import blkhist_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PATH_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        adv,
  input  logic [LANES*ADDR_W-1:0] addr,
  output logic [LAG*PATH_W-1:0]   path_q
);
  logic [PATH_W-1:0] sig   [LANES];
  logic [PATH_W-1:0] pth_q [LAG];
  logic [PATH_W-1:0] pth_d [LAG];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      sig[i] = '0;
      for (int j = 0; j < ADDR_W; j++)
        sig[i][j % PATH_W] = sig[i][j % PATH_W] ^ addr[i*ADDR_W + j];
    end
  end

  always_comb begin
    for (int k = 0; k < LAG; k++) pth_d[k] = pth_q[k];
    for (int i = 0; i < LANES; i++) begin
      if (adv[i]) begin
        for (int k = LAG-1; k > 0; k--) pth_d[k] = pth_d[k-1];
        pth_d[0] = sig[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) for (int k = 0; k < LAG; k++) pth_q[k] <= '0;
    else     for (int k = 0; k < LAG; k++) pth_q[k] <= pth_d[k];
  end

  for (genvar k = 0; k < LAG; k++) begin : g_pack
    assign path_q[(LAG-1-k)*PATH_W +: PATH_W] = pth_q[k];
  end
endmodule

// File: rtl/blkhist_top.sv
module blkhist_top
  import blkhist_pkg::*;
#(
  parameter int HIST_W = 16,
  parameter int ADDR_W = 12,
  parameter int PATH_W = 2,
  localparam int INFO_W = ADDR_W + HIST_W + LAG*PATH_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        blk_vld,
  input  logic [LANES-1:0]        blk_br,
  input  logic [LANES-1:0]        blk_dir,
  input  logic [LANES-1:0]        blk_half,
  input  logic [LANES*ADDR_W-1:0] blk_addr,
  input  logic [ADDR_W-1:0]       pred_addr,
  input  logic                    restore,
  input  logic [HIST_W-1:0]       restore_val,
  output logic [HIST_W-1:0]       hist_o,
  output logic [INFO_W-1:0]       info_o
);
  logic [LANES-1:0]      adv, ins, hbit;
  logic [HIST_W-1:0]     stale;
  logic [LAG*PATH_W-1:0] path;
  logic [ADDR_W-1:0]     paddr_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    blk_ctl_t ctl;
    assign ctl = '{vld: blk_vld[i], br: blk_br[i], dir: blk_dir[i], half: blk_half[i]};
    blkhist_lane u_lane (.ctl(ctl), .adv(adv[i]), .ins(ins[i]), .hbit(hbit[i]));
  end

  blkhist_snap #(.HIST_W(HIST_W)) u_snap (
    .clk(clk), .rst(rst), .adv(adv), .ins(ins), .hbit(hbit),
    .restore(restore), .restore_val(restore_val),
    .hist_q(hist_o), .stale_q(stale)
  );

  blkhist_path #(.ADDR_W(ADDR_W), .PATH_W(PATH_W)) u_path (
    .clk(clk), .rst(rst), .adv(adv), .addr(blk_addr), .path_q(path)
  );

  always_ff @(posedge clk) begin
    if (rst) paddr_q <= '0;
    else     paddr_q <= pred_addr;
  end

  assign info_o = {paddr_q, stale, path};
endmodule

// File: rtl/blkhist_chk.sv
module blkhist_chk
  import blkhist_pkg::*;
#(
  parameter int HIST_W = 16,
  parameter int ADDR_W = 12,
  parameter int PATH_W = 2,
  localparam int INFO_W = ADDR_W + HIST_W + LAG*PATH_W
) (
  input logic              clk,
  input logic              rst,
  input logic [LANES-1:0]  blk_vld,
  input logic [LANES-1:0]  blk_br,
  input logic [LANES-1:0]  blk_dir,
  input logic [LANES-1:0]  blk_half,
  input logic [ADDR_W-1:0] pred_addr,
  input logic              restore,
  input logic [HIST_W-1:0] restore_val,
  input logic [HIST_W-1:0] hist_o,
  input logic [INFO_W-1:0] info_o
);
  logic [LANES-1:0] ins_c;
  assign ins_c = blk_vld & blk_br;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (hist_o == '0 && info_o == '0)); // R1

  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (rst)
    restore |=> hist_o == $past(restore_val)); // R8

  AST_NO_INSERT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!restore && ins_c == '0) |=> $stable(hist_o)); // R3

  AST_SINGLE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!restore && ins_c == 2'b01 && !blk_vld[1])
    |=> hist_o == {$past(hist_o[HIST_W-2:0]), $past(blk_dir[0] ^ blk_half[0])}); // R2

  AST_DOUBLE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (!restore && ins_c == 2'b11)
    |=> hist_o == {$past(hist_o[HIST_W-3:0]), $past(blk_dir[0] ^ blk_half[0]),
                   $past(blk_dir[1] ^ blk_half[1])}); // R4

  AST_IDLE_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!restore && blk_vld == '0) |=> $stable(info_o[INFO_W-ADDR_W-1:0])); // R6

  AST_ADDR_FIELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> info_o[INFO_W-1 -: ADDR_W] == $past(pred_addr)); // R7
endmodule

bind blkhist_top blkhist_chk #(.HIST_W(HIST_W), .ADDR_W(ADDR_W), .PATH_W(PATH_W)) u_chk (
  .clk(clk), .rst(rst), .blk_vld(blk_vld), .blk_br(blk_br), .blk_dir(blk_dir),
  .blk_half(blk_half), .pred_addr(pred_addr), .restore(restore),
  .restore_val(restore_val), .hist_o(hist_o), .info_o(info_o)
);

// File: tb/test_blkhist_top.sv
module test_blkhist_top;
  localparam int HW = 8;
  localparam int AW = 6;
  localparam int PW = 2;
  localparam int IW = AW + HW + 3*PW;
  localparam real HALF_NS = 4.0;

  logic          clk = 0;
  logic          rst = 1;
  logic [1:0]    blk_vld = 0, blk_br = 0, blk_dir = 0, blk_half = 0;
  logic [2*AW-1:0] blk_addr = 0;
  logic [AW-1:0] pred_addr = 0;
  logic          restore = 0;
  logic [HW-1:0] restore_val = 0;
  logic [HW-1:0] hist_o;
  logic [IW-1:0] info_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [HW-1:0] m_hist;
  logic [HW-1:0] m_snap [3];
  logic [PW-1:0] m_path [3];
  logic [AW-1:0] m_addr;

  always #(HALF_NS) clk = ~clk;

  blkhist_top #(.HIST_W(HW), .ADDR_W(AW), .PATH_W(PW)) i_blkhist_top (
    .clk(clk), .rst(rst), .blk_vld(blk_vld), .blk_br(blk_br), .blk_dir(blk_dir),
    .blk_half(blk_half), .blk_addr(blk_addr), .pred_addr(pred_addr),
    .restore(restore), .restore_val(restore_val), .hist_o(hist_o), .info_o(info_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] fold(input logic [AW-1:0] a);
    logic [PW-1:0] f = '0;
    for (int j = 0; j < AW; j++) f[j % PW] ^= a[j];
    return f;
  endfunction

  task automatic model_step();
    for (int i = 0; i < 2; i++) begin
      if (blk_vld[i]) begin
        m_snap[2] = m_snap[1]; m_snap[1] = m_snap[0]; m_snap[0] = m_hist;
        m_path[2] = m_path[1]; m_path[1] = m_path[0];
        m_path[0] = fold(blk_addr[i*AW +: AW]);
        if (blk_br[i]) m_hist = {m_hist[HW-2:0], blk_dir[i] ^ blk_half[i]};
      end
    end
    if (restore) begin
      m_hist = restore_val;
      for (int k = 0; k < 3; k++) m_snap[k] = restore_val;
    end
    m_addr = pred_addr;
  endtask

  task automatic compare(input string htag);
    check(htag, 32'(hist_o), 32'(m_hist));
    check("R5 stale", 32'(info_o[HW+3*PW-1 -: HW]), 32'(m_snap[2]));
    check("R6 path", 32'(info_o[3*PW-1:0]), 32'({m_path[0], m_path[1], m_path[2]}));
    check("R7 addr", 32'(info_o[IW-1 -: AW]), 32'(m_addr));
  endtask

  initial begin
    #(HALF_NS * 2.0 * 200000.0);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    m_hist = '0; m_addr = '0;
    for (int k = 0; k < 3; k++) begin m_snap[k] = '0; m_path[k] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 hist reset", 32'(hist_o), 0);
    check("R1 info reset", 32'(info_o), 0);
    tag = "R1";
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < 256; c++) begin
        @(negedge clk);
        compare(tag);
        {blk_vld[1], blk_br[1], blk_dir[1], blk_half[1]} = 4'(c >> 4);
        {blk_vld[0], blk_br[0], blk_dir[0], blk_half[0]} = 4'(c);
        blk_addr[AW-1:0]  = AW'(c * 5 + 3 + pass);
        blk_addr[2*AW-1:AW] = AW'(c * 11 + 7);
        pred_addr   = AW'(c * 3 + pass);
        restore     = (c % 37) == 36;
        restore_val = HW'(c * 13 + 1);
        if (restore) tag = "R8 restore";
        else if ((blk_vld & blk_br) == 2'b11) tag = "R4 two bits";
        else if ((blk_vld & blk_br) == 2'b00) tag = "R3 no insert";
        else if (!blk_vld[0]) tag = "R9 lane1 alone";
        else tag = "R2 one bit";
        model_step();
      end
    end
    @(negedge clk);
    compare(tag);
    blk_vld = 0; restore = 0;
    model_step();
    @(negedge clk);
    compare("R3 idle");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule